// File: doc/BRIEF.md
# SHA-256 Message Padding Unit

This unit stands between a 32-bit message word stream and a SHA-256 compression core. It passes the message words through unchanged. After the final word it appends the standard padding: a single 1 bit, a run of zero bits, and the 64-bit message length in bits. The output always ends on a 512-bit boundary, which is 16 words. The upstream side supplies only the real message. It tags the final beat with the number of meaningful bytes in that word and with the total length in bits. The unit works out where the marker and the length go.

Words are big-endian: byte lane 0 occupies bits 31:24. The marker byte 0x80 is merged into a partially filled final word. If the final word is full, the marker is emitted as a word of its own. If the length does not fit behind the marker in the current block, one extra block of padding is produced. The output is a valid/ready stream. A flag marks the last word of every 16-word block, so the core knows when to start its rounds.

Top module: `sha2_pad_unit`

## Requirements
- R1: A message beat that is not the final beat, or a final beat with in_nbytes = 4, is forwarded with its data unchanged.
- R2: A final beat with in_nbytes = n, where n is 1 to 3, is emitted keeping byte lanes 0..n-1 (lane 0 = bits 31:24), with 0x80 in lane n and zero in every lower lane, whatever the input held there. Example: n = 1 gives 0xXX800000.
- R3: After a final beat with in_nbytes = 4, the next output word is a separate marker word 0x80000000.
- R4: A final beat with in_nbytes = 0 carries no message data: its data is ignored and 0x80000000 is emitted in its slot. An empty message therefore yields 0x80000000, 13 zero words, then two zero length words.
- R5: After the marker, zero words fill the block up to slot 13 (slots numbered 0 to 15). Slot 14 carries length bits 63:32 and slot 15 carries length bits 31:0.
- R6: If the marker lands in slot 14 or 15, the rest of that block is zero-filled. A further block follows with zeros in slots 0 to 13 and the length in slots 14 and 15.
- R7: out_blk_end is high exactly on every 16th accepted output word. Every message produces a whole number of 16-word blocks.
- R8: While out_valid is high and out_ready is low, out_valid, out_data and out_blk_end hold their values, and no word is lost or repeated.
- R9: in_ready is never high while out_ready is low. It stays low from the cycle after the final beat is accepted until the length low word has been accepted.
- R10: After reset the unit is at slot 0 and waiting for a message. out_valid is low while in_valid is low, and in_ready follows out_ready.
- R11: The length is captured when the final beat is accepted. Later changes on in_len_bits do not affect the length words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Message beat valid |
| in_ready | output | 1 | Message beat accepted when high together with in_valid |
| in_data | input | 32 | Message word, big-endian |
| in_last | input | 1 | Final beat of the message |
| in_nbytes | input | 3 | Meaningful bytes in the final beat, 0 to 4 |
| in_len_bits | input | 64 | Total message length in bits, valid with the final beat |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | 32 | Message or padding word |
| out_blk_end | output | 1 | Word occupies the last slot of a 512-bit block |

## Verification
The marker merge and the block boundary can fall on the same beat. A 62-byte message puts the merged final word into slot 15, so the word carrying 0x80 must also raise out_blk_end. That beat must then force a full extra block of 14 zero words before the length. The bench judges it by rebuilding the padded byte stream on its own and comparing every word and every boundary flag. It repeats the check with a 56-byte message, whose separate marker word lands in slot 14, and under downstream stalls, so that a held word and a state change meet at the same edge.

// File: rtl/sha2_pad_pkg.sv
package sha2_pad_pkg;

    parameter int WORD_W      = 32;
    parameter int BLOCK_WORDS = 16;
    parameter int LEN_W       = 64;

    localparam int BYTES    = WORD_W / 8;
    localparam int NB_W     = $clog2(BYTES + 1);
    localparam int SLOT_W   = $clog2(BLOCK_WORDS);
    localparam int LEN_SLOT = BLOCK_WORDS - 2;     // first of the two length slots

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [SLOT_W-1:0] slot_t;
    typedef logic [NB_W-1:0]   nbytes_t;

    typedef enum logic [2:0] {
        PS_MSG,
        PS_MARK,
        PS_ZERO,
        PS_LHI,
        PS_LLO
    } pad_state_e;

    typedef struct packed {
        word_t data;
        logic  blk_end;
    } pad_beat_t;

    // Keep the first n byte lanes, put 0x80 in lane n, clear the rest.
    function automatic word_t merge_marker(word_t w, nbytes_t n);
        word_t r;
        r = '0;
        for (int b = 0; b < BYTES; b++) begin
            if (b < int'(n))
                r[WORD_W-1-8*b -: 8] = w[WORD_W-1-8*b -: 8];
            else if (b == int'(n))
                r[WORD_W-1-8*b -: 8] = 8'h80;
        end
        return r;
    endfunction

endpackage

// File: rtl/pad_slot_ctr.sv
module pad_slot_ctr
    import sha2_pad_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  step,
    output slot_t slot,
    output logic  at_end
);
    always_ff @(posedge clk) begin
        if (rst)
            slot <= '0;
        else if (step)
            slot <= (slot == slot_t'(BLOCK_WORDS - 1)) ? '0 : slot + 1'b1;
    end

    assign at_end = (slot == slot_t'(BLOCK_WORDS - 1));
endmodule

// File: rtl/pad_seq.sv
module pad_seq
    import sha2_pad_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       last_fire,
    input  logic       last_full,
    input  logic       out_fire,
    input  slot_t      slot,
    output pad_state_e state
);
    pad_state_e nxt;
    logic       len_next;

    // the word now leaving sits just before the length slots
    assign len_next = (slot == slot_t'(LEN_SLOT - 1));

    always_comb begin
        nxt = state;
        unique case (state)
            PS_MSG:  if (last_fire)
                         nxt = last_full ? PS_MARK : (len_next ? PS_LHI : PS_ZERO);
            PS_MARK: if (out_fire) nxt = len_next ? PS_LHI : PS_ZERO;
            PS_ZERO: if (out_fire && len_next) nxt = PS_LHI;
            PS_LHI:  if (out_fire) nxt = PS_LLO;
            PS_LLO:  if (out_fire) nxt = PS_MSG;
            default: nxt = PS_MSG;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= PS_MSG;
        else     state <= nxt;
    end
endmodule

// File: rtl/sha2_pad_unit.sv
module sha2_pad_unit
    import sha2_pad_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_last,
    input  logic [NB_W-1:0]   in_nbytes,
    input  logic [LEN_W-1:0]  in_len_bits,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic              out_blk_end
);
    pad_state_e       state;
    slot_t            slot;
    logic             at_end;
    logic             out_fire;
    logic             last_fire;
    logic             last_full;
    logic [LEN_W-1:0] len_q;
    pad_beat_t        beat;

    assign in_ready  = out_ready && (state == PS_MSG);
    assign out_valid = (state == PS_MSG) ? in_valid : 1'b1;
    assign out_fire  = out_valid && out_ready;
    assign last_fire = in_valid && in_ready && in_last;
    assign last_full = (in_nbytes >= nbytes_t'(BYTES));

    always_ff @(posedge clk) begin
        if (rst)
            len_q <= '0;
        else if (last_fire)
            len_q <= in_len_bits;
    end

    always_comb begin
        beat.blk_end = out_valid && at_end;
        unique case (state)
            PS_MSG:  beat.data = (in_last && !last_full) ? merge_marker(in_data, in_nbytes)
                                                         : in_data;
            PS_MARK: beat.data = merge_marker('0, '0);
            PS_LHI:  beat.data = len_q[LEN_W-1 -: WORD_W];
            PS_LLO:  beat.data = len_q[WORD_W-1:0];
            default: beat.data = '0;
        endcase
    end

    assign out_data    = beat.data;
    assign out_blk_end = beat.blk_end;

    pad_slot_ctr i_slot (
        .clk    (clk),
        .rst    (rst),
        .step   (out_fire),
        .slot   (slot),
        .at_end (at_end)
    );

    pad_seq i_seq (
        .clk       (clk),
        .rst       (rst),
        .last_fire (last_fire),
        .last_full (last_full),
        .out_fire  (out_fire),
        .slot      (slot),
        .state     (state)
    );
endmodule

// File: rtl/sha2_pad_unit_chk.sv
module sha2_pad_unit_chk
    import sha2_pad_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_last,
    input logic [NB_W-1:0]   in_nbytes,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_data,
    input logic              out_blk_end
);
    slot_t seen;

    always_ff @(posedge clk) begin
        if (rst)
            seen <= '0;
        else if (out_valid && out_ready)
            seen <= seen + 1'b1;
    end

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_blk_end));

    assert_ready_gated_R9: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> out_ready);

    assert_full_marker_R3: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && in_last && in_nbytes == NB_W'(BYTES)
        |=> out_valid && !in_ready && out_data == {8'h80, {(WORD_W-8){1'b0}}});

    assert_empty_marker_R4: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && in_last && in_nbytes == '0
        |-> out_data == {8'h80, {(WORD_W-8){1'b0}}});

    assert_blk_flag_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_blk_end == (seen == slot_t'(BLOCK_WORDS - 1)));
endmodule

bind sha2_pad_unit sha2_pad_unit_chk i_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_last     (in_last),
    .in_nbytes   (in_nbytes),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_data    (out_data),
    .out_blk_end (out_blk_end)
);

// File: tb/test_sha2_pad_unit.sv
`timescale 1ns/100ps
module test_sha2_pad_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        in_last = 1'b0;
    logic [2:0]  in_nbytes = '0;
    logic [63:0] in_len_bits = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;
    logic        out_blk_end;

    int n_checks = 0;
    int n_fail   = 0;
    bit stall    = 1'b0;
    bit done     = 1'b0;
    int cyc      = 0;

    logic [31:0] got_d[$];
    logic        got_e[$];
    bit          hold_pend = 1'b0;
    logic [31:0] hold_d;
    logic        hold_e;

    always #2.5 clk = ~clk;

    sha2_pad_unit i_sha2_pad_unit (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_last(in_last), .in_nbytes(in_nbytes), .in_len_bits(in_len_bits),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_blk_end(out_blk_end)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // downstream ready pattern
    always @(negedge clk) begin
        cyc++;
        out_ready = !(stall && (cyc % 3 == 1));
    end

    // collector and stall-hold check, sampled well before the next rising edge
    always @(negedge clk) begin
        #2;
        if (!rst) begin
            if (hold_pend)
                chk(out_valid && out_data == hold_d && out_blk_end == hold_e, "R8",
                    {31'd0, out_valid, out_data}, {32'd1, hold_d});
            hold_pend = out_valid && !out_ready;
            hold_d    = out_data;
            hold_e    = out_blk_end;
            if (out_valid && out_ready) begin
                got_d.push_back(out_data);
                got_e.push_back(out_blk_end);
            end
        end
    end

    function automatic logic [7:0] mb(input int i);
        return 8'(i * 13 + 7);
    endfunction

    task automatic send_beat(input logic [31:0] d, input logic l, input logic [2:0] n, input logic [63:0] len);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_last = l; in_nbytes = n; in_len_bits = len;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
    endtask

    task automatic run_msg(input int nb, input bit stall_on);
        logic [63:0] lenv;
        logic [7:0]  eb[$];
        int          nfull, rem, exp_n;
        logic [31:0] w;
        string       tag;
        lenv  = {8'h5A, 24'(nb), 32'(nb * 8)};
        nfull = nb / 4;
        rem   = nb % 4;
        for (int i = 0; i < nb; i++) eb.push_back(mb(i));
        eb.push_back(8'h80);
        while (eb.size() % 64 != 56) eb.push_back(8'h00);
        for (int i = 7; i >= 0; i--) eb.push_back(lenv[8*i +: 8]);
        exp_n = eb.size() / 4;
        got_d.delete(); got_e.delete();
        stall = stall_on;

        if (nb == 0)
            send_beat(32'hDEADBEEF, 1'b1, 3'd0, lenv);
        for (int i = 0; i < nfull; i++)
            send_beat({mb(4*i), mb(4*i+1), mb(4*i+2), mb(4*i+3)},
                      (rem == 0) && (i == nfull - 1), 3'd4, lenv);
        if (rem > 0) begin
            w = 32'hEEEEEEEE;
            for (int b = 0; b < rem; b++) w[31-8*b -: 8] = mb(4*nfull + b);
            send_beat(w, 1'b1, 3'(rem), lenv);
        end

        // padding phase: upstream offers junk and a changed length
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            if (got_d.size() >= exp_n) break;
            in_valid = 1'b1; in_last = 1'b0; in_data = 32'h0BAD0BAD;
            in_len_bits = 64'hFFFF_0000_FFFF_0000;
            #1;
            chk(in_ready == 1'b0, "R9", {63'd0, in_ready}, 64'd0);
        end
        in_valid = 1'b0;
        stall = 1'b0;

        chk(got_d.size() == exp_n && exp_n % 16 == 0, "R7 word count",
            64'(got_d.size()), 64'(exp_n));
        for (int i = 0; i < exp_n && i < got_d.size(); i++) begin
            if (i < nfull)                   tag = "R1";
            else if (i == nfull && nb == 0)  tag = "R4";
            else if (i == nfull && rem > 0)  tag = "R2";
            else if (i == nfull)             tag = "R3";
            else if (i >= exp_n - 2)         tag = "R5/R11 length";
            else if (exp_n > 16 && i >= exp_n - 16 && nb % 64 >= 56) tag = "R6";
            else                             tag = "R5";
            chk(got_d[i] == {eb[4*i], eb[4*i+1], eb[4*i+2], eb[4*i+3]}, tag,
                64'(got_d[i]), 64'({eb[4*i], eb[4*i+1], eb[4*i+2], eb[4*i+3]}));
            chk(got_e[i] == (i % 16 == 15), "R7 block end", 64'(got_e[i]), 64'(i % 16 == 15));
        end
    endtask

    task automatic test_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        chk(out_valid == 1'b0, "R10 out_valid", 64'(out_valid), 64'd0);
        chk(out_blk_end == 1'b0, "R10 blk_end", 64'(out_blk_end), 64'd0);
        rst = 1'b0;
        @(negedge clk); #1;
        chk(in_ready == out_ready, "R10 in_ready", 64'(in_ready), 64'(out_ready));
        chk(out_valid == 1'b0, "R10 idle", 64'(out_valid), 64'd0);
    endtask

    task automatic test_empty();           run_msg(0,   1'b0); endtask
    task automatic test_one_extra_byte();  run_msg(5,   1'b0); endtask
    task automatic test_three_bytes();     run_msg(3,   1'b0); endtask
    task automatic test_full_last();       run_msg(8,   1'b0); endtask
    task automatic test_marker_slot13();   run_msg(55,  1'b0); endtask
    task automatic test_marker_slot14();   run_msg(56,  1'b0); endtask
    task automatic test_merge_at_end();    run_msg(62,  1'b0); endtask
    task automatic test_block_stall();     run_msg(64,  1'b1); endtask
    task automatic test_long_stall();      run_msg(130, 1'b1); endtask
    task automatic test_back_to_back();    run_msg(62,  1'b1); run_msg(1, 1'b0); endtask

    initial begin
        test_reset();
        test_empty();
        test_one_extra_byte();
        test_three_bytes();
        test_full_last();
        test_marker_slot13();
        test_marker_slot14();
        test_merge_at_end();
        test_block_stall();
        test_long_stall();
        test_back_to_back();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule